// File: doc/BRIEF.md
# Strap-Latched Frequency Select Mux

This block chooses the frequency-select code and the spread-spectrum enable that a clock synthesizer's PLL programming logic consumes. Five frequency straps and one 24/48 MHz select strap share package pins with clock outputs. After reset those pins are held as inputs for a parameterized number of clocks. The block samples the straps once and then tells the pad logic to turn the pins into outputs.

A source-select bit in a configuration byte picks the code that reaches the output. When that bit is clear, the captured straps are used. When it is set, a code is gathered from scattered bits of the same byte. The chosen code and the spread enable are registered. A one-cycle strobe marks every cycle in which either of them takes a new value, so the downstream PLL logic knows when to relock.

Top module: `freq_strap_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, freqCode is 5'b11111, spreadEn is 0, pinsDriveOut is 0, codeChanged is 0 and sel24Mhz is 1. These values match what weak pull-ups give on unstrapped pins.
- R2: After reset is released, pinsDriveOut stays 0 for HOLD_CYCLES - 1 rising edges. It becomes 1 after the HOLD_CYCLES-th edge and stays 1 until the next reset.
- R3: The strap pins are sampled exactly once, on the edge where pinsDriveOut rises. Later changes on strapPins or refStrapPin have no effect on sel24Mhz or on the strap-derived code.
- R4: sel24Mhz shows the captured refStrapPin value: 0 selects 48 MHz and 1 selects 24 MHz.
- R5: When cfgByte bit 3 is 0, freqCode one clock later equals the captured straps, with strapPins[i] giving FS bit i.
- R6: When cfgByte bit 3 is 1, freqCode one clock later takes its bits from cfgByte as follows: FS4 from bit 2, FS3 from bit 7, FS2 from bit 6, FS1 from bit 5 and FS0 from bit 4.
- R7: spreadEn equals cfgByte bit 1 from one clock earlier. A value of 1 enables spread spectrum.
- R8: codeChanged is 1 in exactly those cycles where freqCode or spreadEn differs from its value in the previous cycle.
- R9: When cfgByte bit 3 returns from 1 to 0, freqCode goes back to the captured strap code one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapPins | input | 5 | Frequency strap pin values, bit i = FS bit i |
| refStrapPin | input | 1 | 24/48 MHz select strap pin value |
| cfgByte | input | 8 | Configuration byte: bit 1 spread, bit 3 source, bits 2 and 7:4 register code |
| freqCode | output | 5 | Registered effective frequency-select code FS[4:0] |
| spreadEn | output | 1 | Registered spread-spectrum enable |
| pinsDriveOut | output | 1 | 1 = shared pins are released to output mode |
| sel24Mhz | output | 1 | Captured output select: 1 = 24 MHz, 0 = 48 MHz |
| codeChanged | output | 1 | One-cycle strobe when freqCode or spreadEn changes |

## Verification
The assertions check the following on every cycle:
- pinsDriveOut stays high once it has risen, and never rises before the hold window has elapsed.
- sel24Mhz is frozen once the pins are driven.
- spreadEn and the register-mode code follow the configuration byte with one cycle of delay.
- The change strobe matches an actual change in the outputs.

Some behaviours can only be shown by the bench's scenarios:
- Which strap values were sampled, and that pin activity after capture is ignored.
- That the hardware code comes back after leaving register mode.
- The exact edge where the pins are released.

// File: rtl/strap_sel_pkg.sv
package strap_sel_pkg;
  localparam int FS_W = 5;

  // Byte positions used by the configuration decode
  localparam int SPREAD_BIT = 1;
  localparam int SOURCE_BIT = 3;

  // Position of FS bit i inside the configuration byte in register mode
  localparam int FS_POS [FS_W] = '{4, 5, 6, 7, 2};

  typedef struct packed {
    logic capture;   // sample the strap pins on this edge
    logic holding;   // pins are still inputs
  } ctrlStrobes_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_sel_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strobes,
  output logic         pinsDriveOut
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             released;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      released <= 1'b0;
    end else if (!released) begin
      if (holdCnt == LAST) released <= 1'b1;
      else                 holdCnt  <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.holding = !released;
    strobes.capture = !released && (holdCnt == LAST);
  end

  assign pinsDriveOut = released;
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [FS_W-1:0] strapPins,
  input  logic            refStrapPin,
  input  logic [7:0]      cfgByte,
  output logic [FS_W-1:0] freqCode,
  output logic            spreadEn,
  output logic            sel24Mhz,
  output logic            codeChanged
);
  logic [FS_W-1:0] strapCode;
  logic [FS_W-1:0] regCode;
  logic [FS_W-1:0] nextCode;
  logic            nextSpread;

  // One-time strap capture; the reset value matches unstrapped pull-ups
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapCode <= '1;
      sel24Mhz  <= 1'b1;
    end else if (strobes.capture) begin
      strapCode <= strapPins;
      sel24Mhz  <= refStrapPin;
    end
  end

  // Gather the scattered register-mode code
  for (genvar i = 0; i < FS_W; i++) begin : g_regMap
    assign regCode[i] = cfgByte[FS_POS[i]];
  end

  always_comb begin
    nextCode   = cfgByte[SOURCE_BIT] ? regCode : strapCode;
    nextSpread = cfgByte[SPREAD_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqCode    <= '1;
      spreadEn    <= 1'b0;
      codeChanged <= 1'b0;
    end else begin
      freqCode    <= nextCode;
      spreadEn    <= nextSpread;
      codeChanged <= (nextCode != freqCode) || (nextSpread != spreadEn);
    end
  end
endmodule

// File: rtl/freq_strap_select.sv
module freq_strap_select
  import strap_sel_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] strapPins,
  input  logic       refStrapPin,
  input  logic [7:0] cfgByte,
  output logic [4:0] freqCode,
  output logic       spreadEn,
  output logic       pinsDriveOut,
  output logic       sel24Mhz,
  output logic       codeChanged
);
  ctrlStrobes_t strobes;

  strap_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .pinsDriveOut (pinsDriveOut)
  );

  strap_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .strapPins   (strapPins),
    .refStrapPin (refStrapPin),
    .cfgByte     (cfgByte),
    .freqCode    (freqCode),
    .spreadEn    (spreadEn),
    .sel24Mhz    (sel24Mhz),
    .codeChanged (codeChanged)
  );
endmodule

// File: rtl/freq_strap_select_chk.sv
module freq_strap_select_chk #(
  parameter int HOLD_CYCLES = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] cfgByte,
  input logic [4:0] freqCode,
  input logic       spreadEn,
  input logic       pinsDriveOut,
  input logic       sel24Mhz,
  input logic       codeChanged
);
  localparam int CW = $clog2(HOLD_CYCLES + 1) + 1;

  logic          pastValid;
  logic [CW-1:0] edgesSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      edgesSeen <= '0;
    end else begin
      pastValid <= 1'b1;
      if (edgesSeen < CW'(HOLD_CYCLES)) edgesSeen <= edgesSeen + 1'b1;
    end
  end

  // R2: once released, pins stay driven until reset
  assert_dir_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    pinsDriveOut |=> pinsDriveOut);

  // R2: no release before the hold window has elapsed
  assert_no_early_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    pinsDriveOut |-> (edgesSeen >= CW'(HOLD_CYCLES)));

  // R3: the captured select strap is frozen after release
  assert_sel_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    pinsDriveOut |=> $stable(sel24Mhz));

  // R7: spread enable follows the configuration one cycle later
  assert_spread_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (spreadEn == $past(cfgByte[1])));

  // R6: register-mode code mapping
  assert_reg_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(cfgByte[3])) |->
      (freqCode == {$past(cfgByte[2]), $past(cfgByte[7:4])}));

  // R8: strobe matches an actual output change
  assert_strobe_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (codeChanged ==
      ((freqCode != $past(freqCode)) || (spreadEn != $past(spreadEn)))));
endmodule

bind freq_strap_select freq_strap_select_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgByte      (cfgByte),
  .freqCode     (freqCode),
  .spreadEn     (spreadEn),
  .pinsDriveOut (pinsDriveOut),
  .sel24Mhz     (sel24Mhz),
  .codeChanged  (codeChanged)
);

// File: tb/test_freq_strap_select.sv
`timescale 1ns/1ps
module test_freq_strap_select;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] strapPins = 5'b11111;
  logic       refStrapPin = 1'b1;
  logic [7:0] cfgByte = 8'h00;
  logic [4:0] freqCode;
  logic       spreadEn, pinsDriveOut, sel24Mhz, codeChanged;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [4:0] expStrap;
  logic       expSel;
  logic [4:0] prevCode;
  logic       prevSpread;

  always #2.5 clk = ~clk;

  freq_strap_select #(.HOLD_CYCLES(HOLD)) i_freq_strap_select (
    .clk(clk), .rstN(rstN), .strapPins(strapPins), .refStrapPin(refStrapPin),
    .cfgByte(cfgByte), .freqCode(freqCode), .spreadEn(spreadEn),
    .pinsDriveOut(pinsDriveOut), .sel24Mhz(sel24Mhz), .codeChanged(codeChanged)
  );

  function automatic logic [4:0] mapReg(input logic [7:0] b);
    return {b[2], b[7], b[6], b[5], b[4]};
  endfunction

  function automatic logic [4:0] expCodeOf(input logic [7:0] b, input logic [4:0] straps);
    return b[3] ? mapReg(b) : straps;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reset and power-up capture sequence: covers R1..R5 and R3 ignore
  task automatic powerUp(input logic [4:0] straps, input logic refv);
    @(negedge clk);
    rstN = 1'b0; cfgByte = 8'h00;
    strapPins = straps; refStrapPin = refv;
    repeat (2) tick();
    check("R1 code", {3'b0, freqCode}, 8'h1f);
    check("R1 spread", {7'b0, spreadEn}, 8'h0);
    check("R1 dir", {7'b0, pinsDriveOut}, 8'h0);
    check("R1 strobe", {7'b0, codeChanged}, 8'h0);
    check("R1 sel", {7'b0, sel24Mhz}, 8'h1);
    rstN = 1'b1;
    repeat (HOLD - 1) tick();
    check("R2 still input", {7'b0, pinsDriveOut}, 8'h0);
    tick();
    check("R2 released", {7'b0, pinsDriveOut}, 8'h1);
    check("R4 sel", {7'b0, sel24Mhz}, {7'b0, refv});
    tick();
    check("R5 strap code", {3'b0, freqCode}, {3'b0, straps});
    check("R8 capture strobe", {7'b0, codeChanged}, {7'b0, straps != 5'b11111});
    strapPins = ~straps; refStrapPin = ~refv;
    repeat (3) tick();
    check("R3 code ignores pins", {3'b0, freqCode}, {3'b0, straps});
    check("R3 sel ignores pins", {7'b0, sel24Mhz}, {7'b0, refv});
    check("R2 stays driven", {7'b0, pinsDriveOut}, 8'h1);
    expStrap = straps; expSel = refv;
    prevCode = straps; prevSpread = 1'b0;
  endtask

  task automatic applyCfg(input logic [7:0] b, input string tag);
    logic [4:0] ec;
    cfgByte = b;
    tick();
    ec = expCodeOf(b, expStrap);
    check({tag, " R6/R5 code"}, {3'b0, freqCode}, {3'b0, ec});
    check({tag, " R7 spread"}, {7'b0, spreadEn}, {7'b0, b[1]});
    check({tag, " R8 strobe"}, {7'b0, codeChanged},
          {7'b0, (ec != prevCode) || (b[1] != prevSpread)});
    prevCode = ec; prevSpread = b[1];
  endtask

  initial begin
    void'($urandom(32'd4711));
    powerUp(5'b10110, 1'b0);
    // Directed register mode, R6 bit mapping: FS4 from bit2 only
    applyCfg(8'b0000_1100, "dir");
    applyCfg(8'b0000_1100, "dir hold");
    applyCfg(8'b1000_1000, "dir fs3");
    applyCfg(8'b1000_1010, "dir spread");
    applyCfg(8'b0000_0010, "R9 back");
    check("R9 strap code", {3'b0, freqCode}, {3'b0, expStrap});
    // Random mix
    for (int i = 0; i < 80; i++) begin
      logic [7:0] b;
      b = 8'($urandom());
      if ((i % 5) == 0) b = cfgByte;
      applyCfg(b, "rnd");
    end
    // Unstrapped pins: all ones, no capture strobe
    powerUp(5'b11111, 1'b1);
    applyCfg(8'h00, "unstrapped");
    powerUp(5'($urandom()), 1'($urandom()));
    for (int i = 0; i < 30; i++) applyCfg(8'($urandom()), "rnd2");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule